// File: doc/BRIEF.md
# Polled FIFO SPI Master

This block is an SPI master that software runs through a small 32-bit register port. Bytes to send go into a 16-entry transmit queue and received bytes come back out of a 16-entry receive queue. Software chooses the clock polarity, the sampling phase, the bit order and a divider of the system clock. It loads separate counts of words to send and words to keep, then sets a run bit. Software drives chip select itself through a pin register. It watches progress by polling the fill levels of the two queues and two sticky completion flags.

A typical transfer has these steps. Lower chip select. Preload up to 16 bytes and write both counts. Set the run bit. Keep refilling the transmit queue and draining the receive queue until both completion flags are set. Then clear the run bit and raise chip select. When the transmit count runs out before the receive count, the engine clocks receive-only words with the data line low. When the transmit queue empties while words are still owed, the serial clock waits at its idle level until more data arrives.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset cs_n is 1 and sck and mosi are 0. The FIFO status register at 0x10C reads 0x0010_0000. The divider reads 2 and the status register at 0x008 reads 0.
- R2: A write to 0x010 pushes its low byte into the transmit queue. Bits 15:8 of 0x10C hold the transmit level and bit 4 is set when 16 entries are held. A push into a full queue is dropped.
- R3: A read of 0x020 returns the oldest received byte and removes it, or returns 0 when the queue is empty. Bits 31:24 of 0x10C hold the receive level and bit 20 is set when that queue is empty.
- R4: In the control register at 0x000, bit 0 is the run bit. Writing 1 to bit 2 empties the transmit queue and writing 1 to bit 3 empties the receive queue. Clearing bit 0 stops shifting at once: sck is back at its idle level two clock edges after the write and no further edges follow.
- R5: Bit 1 of the pin register at 0x00C drives cs_n directly, with 1 for high and 0 for low. cs_n changes only through a write to that register.
- R6: A write to the divider at 0x030 is clamped into the range 2 to 0x7FF. One sck period lasts that many system clocks. The first half, from the idle level to the active level, lasts the divider divided by 2, rounded down.
- R7: In the configuration register at 0x004, bit 2 sets the idle level of sck. With bit 1 at 0, data is sampled on the leading edge of each bit and changed on the trailing edge. With bit 1 at 1, data changes on the leading edge and is sampled on the trailing edge. Bits 16:15 (word size) read as 0, which means 8 bits.
- R8: With bit 13 of 0x004 set, each byte is shifted least significant bit first on both mosi and miso. With bit 13 clear, each byte is shifted most significant bit first.
- R9: The transmit count is at 0x04C and the receive count is at 0x034, and both read back as the words remaining. Each transmit word takes one count when it starts. Each finished word takes one receive count and is stored. When the transmit count is 0 and the receive count is not, words of 0x00 are clocked out. Shifting stops when both counts are 0.
- R10: While the transmit count is non-zero and the transmit queue is empty, no word starts and sck holds its idle level. Shifting resumes once a byte is pushed.
- R11: In the status register at 0x008, bit 0 is set when the last counted word is received and bit 2 is set when the last transmit word finishes. Writing 1 clears a bit. Setting the run bit from 0 clears both bits.
- R12: A word that finishes while the receive queue is full is dropped. It still takes its receive count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data in |

## Verification
The assertions assume that a bus access lasts exactly one cycle and that a write and a read never share a cycle. They also assume that the configuration and the divider are changed only while the run bit is clear. The stimulus tasks drive each strobe for one clock, separate accesses by an idle cycle, and stop the engine before every reconfiguration. The bench's serial slave changes miso only just after an sck transition, so the value the design samples is always a settled one.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [11:0] A_CTRL  = 12'h000;
  localparam logic [11:0] A_CFG   = 12'h004;
  localparam logic [11:0] A_STAT  = 12'h008;
  localparam logic [11:0] A_PIN   = 12'h00C;
  localparam logic [11:0] A_TXD   = 12'h010;
  localparam logic [11:0] A_RXD   = 12'h020;
  localparam logic [11:0] A_DIV   = 12'h030;
  localparam logic [11:0] A_RXCNT = 12'h034;
  localparam logic [11:0] A_TXCNT = 12'h04C;
  localparam logic [11:0] A_FSTAT = 12'h10C;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
  } spi_mode_t;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_FIN} eng_state_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LVL_MAX);
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (level == LVL_MAX)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> (level == '0)); // R3
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_MAX); // R2
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  spi_mode_t        mode,
  input  logic [DIV_W-1:0] div,
  input  logic             want_tx,
  input  logic             want_rx,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             start,
  output logic             start_tx,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic             sck,
  output logic             mosi
);
  eng_state_t       st;
  logic [3:0]       ecnt;
  logic [DIV_W-1:0] hcnt;
  logic [DIV_W-1:0] h_lead, h_trail;
  logic [7:0]       dat, rxs;
  logic [7:0]       load;
  logic [2:0]       bj;
  logic             sck_q, mosi_q;

  function automatic logic [2:0] bit_pos(input logic lsb, input logic [2:0] j);
    return lsb ? j : (3'd7 - j);
  endfunction

  assign h_lead   = div >> 1;
  assign h_trail  = div - h_lead;
  assign start    = (st == ENG_IDLE) && run && (want_tx || want_rx);
  assign start_tx = start && want_tx;
  assign load     = want_tx ? tx_byte : 8'h00;
  assign done     = (st == ENG_FIN);
  assign rx_byte  = rxs;
  assign bj       = ecnt[3:1];
  assign sck      = sck_q;
  assign mosi     = mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ENG_IDLE;
      ecnt   <= '0;
      hcnt   <= '0;
      dat    <= '0;
      rxs    <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      case (st)
        ENG_IDLE: begin
          sck_q <= mode.cpol;
          if (start) begin
            st   <= ENG_SHIFT;
            ecnt <= '0;
            hcnt <= h_lead - 1'b1;
            dat  <= load;
            if (!mode.cpha) mosi_q <= load[bit_pos(mode.lsb, 3'd0)];
          end
        end
        ENG_SHIFT: begin
          if (!run) begin
            st    <= ENG_IDLE;
            sck_q <= mode.cpol;
          end else if (hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
          end else begin
            sck_q <= ~sck_q;
            if (!ecnt[0]) begin
              if (!mode.cpha) rxs[bit_pos(mode.lsb, bj)] <= miso;
              else            mosi_q <= dat[bit_pos(mode.lsb, bj)];
            end else begin
              if (mode.cpha)        rxs[bit_pos(mode.lsb, bj)] <= miso;
              else if (bj != 3'd7)  mosi_q <= dat[bit_pos(mode.lsb, bj + 3'd1)];
            end
            if (ecnt == 4'd15) begin
              st <= ENG_FIN;
            end else begin
              ecnt <= ecnt + 1'b1;
              hcnt <= ecnt[0] ? (h_lead - 1'b1) : (h_trail - 1'b1);
            end
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  AST_HALT_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_SHIFT && !run) |=> (sck == $past(mode.cpol))); // R4
  AST_MOSI_HELD_AT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_SHIFT && run && hcnt == '0 && (ecnt[0] == mode.cpha)) |=> $stable(mosi)); // R7
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int DIV_W = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  output logic        spi_cs_n,
  input  logic        spi_miso
);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);
  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

  logic             run_q, cs_q, rx_done_q, tx_done_q, was_tx_q;
  spi_mode_t        mode_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] txcnt_q, rxcnt_q;

  logic wr_ctrl, wr_cfg, wr_stat, wr_pin, wr_txd, wr_div, wr_rxcnt, wr_txcnt, rd_rxd;
  logic run_rise;

  logic [7:0]    tx_head, rx_head_raw, rx_head, eng_rx;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          eng_start, eng_start_tx, eng_done;
  logic          want_tx, want_rx, rx_push;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);
  assign wr_pin   = bus_wr && (bus_addr == A_PIN);
  assign wr_txd   = bus_wr && (bus_addr == A_TXD);
  assign wr_div   = bus_wr && (bus_addr == A_DIV);
  assign wr_rxcnt = bus_wr && (bus_addr == A_RXCNT);
  assign wr_txcnt = bus_wr && (bus_addr == A_TXCNT);
  assign rd_rxd   = bus_rd && (bus_addr == A_RXD);
  assign run_rise = wr_ctrl && bus_wdata[0] && !run_q;

  assign want_tx  = (txcnt_q != '0) && !tx_empty;
  assign want_rx  = (txcnt_q == '0) && (rxcnt_q != '0);
  assign rx_push  = eng_done && (rxcnt_q != '0);
  assign rx_head  = rx_empty ? 8'h00 : rx_head_raw;

  spi_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(wr_ctrl && bus_wdata[2]),
    .push(wr_txd), .wdata(bus_wdata[7:0]), .pop(eng_start_tx),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_lvl));

  spi_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(wr_ctrl && bus_wdata[3]),
    .push(rx_push), .wdata(eng_rx), .pop(rd_rxd),
    .rdata(rx_head_raw), .full(rx_full), .empty(rx_empty), .level(rx_lvl));

  spi_shift_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .run(run_q), .mode(mode_q), .div(div_q),
    .want_tx(want_tx), .want_rx(want_rx), .tx_byte(tx_head), .miso(spi_miso),
    .start(eng_start), .start_tx(eng_start_tx), .done(eng_done), .rx_byte(eng_rx),
    .sck(spi_sck), .mosi(spi_mosi));

  assign spi_cs_n = cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      mode_q    <= '0;
      cs_q      <= 1'b1;
      div_q     <= DIV_MIN;
      txcnt_q   <= '0;
      rxcnt_q   <= '0;
      was_tx_q  <= 1'b0;
      rx_done_q <= 1'b0;
      tx_done_q <= 1'b0;
    end else begin
      if (wr_ctrl) run_q <= bus_wdata[0];
      if (wr_cfg) begin
        mode_q.cpha <= bus_wdata[1];
        mode_q.cpol <= bus_wdata[2];
        mode_q.lsb  <= bus_wdata[13];
      end
      if (wr_pin) cs_q <= bus_wdata[1];
      if (wr_div) begin
        if (bus_wdata < 32'(DIV_MIN))      div_q <= DIV_MIN;
        else if (bus_wdata > 32'(DIV_MAX)) div_q <= DIV_MAX;
        else                               div_q <= bus_wdata[DIV_W-1:0];
      end
      if (wr_txcnt)          txcnt_q <= bus_wdata[CNT_W-1:0];
      else if (eng_start_tx) txcnt_q <= txcnt_q - 1'b1;
      if (wr_rxcnt)          rxcnt_q <= bus_wdata[CNT_W-1:0];
      else if (rx_push)      rxcnt_q <= rxcnt_q - 1'b1;
      if (eng_start) was_tx_q <= eng_start_tx;

      if (run_rise) begin
        rx_done_q <= 1'b0;
        tx_done_q <= 1'b0;
      end else if (wr_stat) begin
        if (bus_wdata[0]) rx_done_q <= 1'b0;
        if (bus_wdata[2]) tx_done_q <= 1'b0;
      end
      if (eng_done && rxcnt_q == CNT_W'(1))          rx_done_q <= 1'b1;
      if (eng_done && was_tx_q && txcnt_q == '0)     tx_done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= {31'b0, run_q};
        A_CFG:   bus_rdata <= {18'b0, mode_q.lsb, 10'b0, mode_q.cpol, mode_q.cpha, 1'b0};
        A_STAT:  bus_rdata <= {29'b0, tx_done_q, 1'b0, rx_done_q};
        A_PIN:   bus_rdata <= {30'b0, cs_q, 1'b0};
        A_RXD:   bus_rdata <= {24'b0, rx_head};
        A_DIV:   bus_rdata <= 32'(div_q);
        A_RXCNT: bus_rdata <= 32'(rxcnt_q);
        A_TXCNT: bus_rdata <= 32'(txcnt_q);
        A_FSTAT: bus_rdata <= {8'(rx_lvl), 3'b0, rx_empty, 4'b0, 8'(tx_lvl), 3'b0, tx_full, 4'b0};
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    (div_q >= DIV_MIN) && (div_q <= DIV_MAX)); // R6
  AST_CS_BY_BUS_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_cs_n) |-> $past(wr_pin)); // R5
  AST_TXCNT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (txcnt_q > $past(txcnt_q)) |-> $past(wr_txcnt)); // R9
  AST_RXQ_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && !rd_rxd) |=> (rx_lvl == LW'(DEPTH))); // R12
endmodule

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  spi_fifo_master dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference state
  bit m_cs = 1, m_cpol = 0, m_cpha = 0, m_lsb = 0, m_active = 1;

  // behavioural slave
  bit        slave_on = 0;
  int        edges = 0;
  logic [7:0] cap [0:31];
  longint    etime [0:15];

  function automatic logic [7:0] pat(input int w);
    return 8'h5A ^ 8'(w * 37);
  endfunction
  function automatic logic [7:0] txpat(input int k);
    return 8'hA5 + 8'(k * 29);
  endfunction
  function automatic int bpos(input int j);
    return m_lsb ? j : 7 - j;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  always @(spi_sck) begin
    if (slave_on) begin
      int e, w;
      e = edges % 16;
      w = edges / 16;
      if (e < 16 && w < 32 && ((e % 2) == int'(m_cpha))) cap[w][bpos(e / 2)] = spi_mosi;
      if (w == 0) etime[e] = $time;
      edges++;
      spi_miso = pat(edges / 16)[bpos((edges % 16) / 2)];
    end
  end

  task automatic slave_reset();
    edges = 0;
    for (int i = 0; i < 32; i++) cap[i] = 8'hxx;
    spi_miso = pat(0)[bpos(0)];
    slave_on = 1;
  endtask

  // per-clock comparison against the reference state
  always @(posedge clk) begin
    #1;
    if (!rst && !finished) begin
      chk(spi_cs_n == m_cs, "R5 cs_n", 32'(spi_cs_n), 32'(m_cs));
      if (!m_active) chk(spi_sck == m_cpol, "R7 sck idle", 32'(spi_sck), 32'(m_cpol));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    if (a == 12'h00C) m_cs = d[1];
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d === e, req, d, e);
  endtask

  task automatic poll_stat(input logic [31:0] want, input string req);
    logic [31:0] d;
    int n;
    n = 0;
    do begin rd(12'h008, d); n++; end while (((d & want) != want) && n < 4000);
    chk((d & want) == want, req, d, want);
  endtask

  task automatic setup(input bit cpol, input bit cpha, input bit lsb, input int div);
    m_active = 1;
    wr(12'h000, 0);
    wr(12'h004, (32'(lsb) << 13) | (32'(cpol) << 2) | (32'(cpha) << 1));
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb;
    wr(12'h030, 32'(div));
    repeat (3) @(posedge clk);
  endtask

  task automatic xfer(input bit cpol, input bit cpha, input bit lsb, input int div, input int n, input string req);
    setup(cpol, cpha, lsb, div);
    slave_reset();
    wr(12'h00C, 0);
    for (int k = 0; k < n; k++) wr(12'h010, 32'(txpat(k)));
    wr(12'h04C, 32'(n));
    wr(12'h034, 32'(n));
    wr(12'h000, 1);
    expect_rd(12'h008, 0, "R11 flags cleared on run start");
    poll_stat(5, "R11 both complete flags");
    wr(12'h000, 0);
    wr(12'h00C, 2);
    chk(edges == 16 * n, {req, " R9 edge count"}, 32'(edges), 32'(16 * n));
    for (int k = 0; k < n; k++) chk(cap[k] === txpat(k), {req, " mosi byte"}, 32'(cap[k]), 32'(txpat(k)));
    for (int k = 0; k < n; k++) expect_rd(12'h020, 32'(pat(k)), {req, " miso byte"});
    expect_rd(12'h04C, 0, "R9 txcnt exhausted");
    expect_rd(12'h034, 0, "R9 rxcnt exhausted");
    slave_on = 0;
    repeat (2) @(posedge clk);
    m_active = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int e0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n === 1'b1, "R1 cs_n", 32'(spi_cs_n), 1);
    chk(spi_sck === 1'b0, "R1 sck", 32'(spi_sck), 0);
    chk(spi_mosi === 1'b0, "R1 mosi", 32'(spi_mosi), 0);
    m_active = 0;
    expect_rd(12'h10C, 32'h0010_0000, "R1 fifo status");
    expect_rd(12'h030, 2, "R1 divider");
    expect_rd(12'h008, 0, "R1 status");
    expect_rd(12'h004, 0, "R7 word size field");

    // R5 chip select
    wr(12'h00C, 0);
    chk(spi_cs_n === 1'b0, "R5 cs low", 32'(spi_cs_n), 0);
    wr(12'h00C, 2);
    chk(spi_cs_n === 1'b1, "R5 cs high", 32'(spi_cs_n), 1);

    // R2 / R3 queue behaviour
    for (int k = 0; k < 16; k++) wr(12'h010, 32'(k));
    expect_rd(12'h10C, 32'h0010_1010, "R2 tx full level 16");
    wr(12'h010, 32'hEE);
    expect_rd(12'h10C, 32'h0010_1010, "R2 push to full dropped");
    wr(12'h000, 4);
    expect_rd(12'h10C, 32'h0010_0000, "R4 tx flush");
    expect_rd(12'h020, 0, "R3 pop empty returns 0");

    // R6 divider clamp
    wr(12'h030, 0);      expect_rd(12'h030, 2, "R6 clamp low");
    wr(12'h030, 32'hFFFF); expect_rd(12'h030, 32'h7FF, "R6 clamp high");
    wr(12'h030, 5);      expect_rd(12'h030, 5, "R6 in range");

    // R7 / R8 transfers in all phase and polarity combinations
    xfer(0, 0, 0, 4, 3, "R7 R8 mode0 msb");
    xfer(1, 1, 1, 5, 2, "R7 R8 mode3 lsb");
    chk(etime[1] - etime[0] == 3 * PERIOD, "R6 trailing half", 32'(etime[1] - etime[0]), 32'(3 * PERIOD));
    chk(etime[2] - etime[1] == 2 * PERIOD, "R6 leading half", 32'(etime[2] - etime[1]), 32'(2 * PERIOD));
    xfer(0, 1, 0, 2, 4, "R7 R8 mode1 msb");
    xfer(1, 0, 1, 7, 1, "R7 R8 mode2 lsb");

    // R11 write one to clear
    expect_rd(12'h008, 5, "R11 flags held");
    wr(12'h008, 1); expect_rd(12'h008, 4, "R11 clear rx flag");
    wr(12'h008, 4); expect_rd(12'h008, 0, "R11 clear tx flag");

    // R10 stall on empty transmit queue
    setup(1, 0, 1, 7);
    slave_reset();
    wr(12'h00C, 0);
    wr(12'h04C, 2); wr(12'h034, 2);
    wr(12'h010, 32'(txpat(0)));
    wr(12'h000, 1);
    for (int i = 0; i < 400 && edges < 16; i++) @(posedge clk);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk(edges == 16, "R10 stalled edge count", 32'(edges), 16);
    chk(spi_sck === 1'b1, "R10 sck idle while stalled", 32'(spi_sck), 1);
    expect_rd(12'h04C, 1, "R10 txcnt remaining");
    expect_rd(12'h008, 0, "R10 not complete");
    wr(12'h010, 32'(txpat(1)));
    poll_stat(5, "R10 resumed to completion");
    chk(cap[1] === txpat(1), "R10 second byte", 32'(cap[1]), 32'(txpat(1)));
    wr(12'h000, 0);
    expect_rd(12'h020, 32'(pat(0)), "R10 rx byte 0");
    expect_rd(12'h020, 32'(pat(1)), "R10 rx byte 1");

    // R9 receive-only words, then R4 receive flush
    slave_reset();
    wr(12'h04C, 0); wr(12'h034, 3);
    wr(12'h000, 1);
    poll_stat(1, "R9 rx-only complete");
    expect_rd(12'h008, 1, "R11 no tx flag without tx words");
    for (int k = 0; k < 3; k++) chk(cap[k] === 8'h00, "R9 rx-only sends zero", 32'(cap[k]), 0);
    expect_rd(12'h020, 32'(pat(0)), "R9 rx-only byte 0");
    expect_rd(12'h020, 32'(pat(1)), "R9 rx-only byte 1");
    wr(12'h000, 8);
    expect_rd(12'h10C, 32'h0010_0000, "R4 rx flush");

    // R12 receive queue overflow
    setup(1, 0, 1, 2);
    slave_reset();
    wr(12'h04C, 0); wr(12'h034, 17);
    wr(12'h000, 1);
    poll_stat(1, "R12 run finished");
    wr(12'h000, 0);
    expect_rd(12'h10C, 32'h1000_0000, "R12 rx level 16");
    for (int k = 0; k < 16; k++) expect_rd(12'h020, 32'(pat(k)), "R12 kept bytes");
    expect_rd(12'h020, 0, "R12 17th byte dropped");
    expect_rd(12'h034, 0, "R12 count still taken");

    // R4 halt mid-word
    setup(0, 0, 0, 8);
    slave_reset();
    wr(12'h04C, 1); wr(12'h034, 1);
    wr(12'h010, 32'h3C);
    wr(12'h000, 1);
    repeat (20) @(posedge clk);
    wr(12'h000, 0);
    @(posedge clk); #1;
    chk(spi_sck === 1'b0, "R4 sck idle after halt", 32'(spi_sck), 0);
    e0 = edges;
    repeat (100) @(posedge clk);
    #1;
    chk(edges == e0, "R4 no edges after halt", 32'(edges), 32'(e0));
    expect_rd(12'h008, 0, "R4 no completion after halt");
    expect_rd(12'h04C, 0, "R4 txcnt taken at start");
    slave_on = 0;
    m_active = 0;
    repeat (4) @(posedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule